// File: doc/BRIEF.md
# SDRAM Read Burst Data Sequencer

This block models the read data path of one SDRAM bank. When a read command arrives together with a starting column, it walks a sequence of column addresses. Each column fetches one word from a small internal synchronous array. The words come out one per clock, starting a programmable number of clocks (the CAS latency) after the command. While words are on the output, a drive enable is high. This enable stands in for the data pin drivers. It drops when the burst is over, which models the pins going to high impedance.

Two static configuration inputs set the burst length and the CAS latency. A fixed burst of 1, 2, 4 or 8 words steps through the columns in order and wraps inside the aligned block that holds the starting column. A full-page burst steps through all columns, wraps from the last column back to column 0, and runs until a stop input is sampled. A new read during a burst starts the sequence again from the new column, with no idle cycle on the output.

The column sequencer is a state machine with three states. ST_IDLE means no burst is running. ST_FIXED means a counted burst is running. ST_PAGE means an open-ended full-page burst is running. Its transitions are:
- LAUNCH: a read from any state enters ST_FIXED or ST_PAGE. A read from a busy state is the RESTART case.
- STEP: stays in ST_FIXED or ST_PAGE and advances the column.
- FINISH: ST_FIXED returns to ST_IDLE after its last word.
- STOP: ST_FIXED or ST_PAGE returns to ST_IDLE on the stop input.

The column stream then passes through a latency delay line with a selectable tap. After the tap comes the registered array read.

Top module: `sdram_rd_seq`

## Requirements
- R1: If a read command is sampled on rising edge T, the first word (from the starting column) appears with `dq_oe` high just after edge T+L. Here L is `cfg_cl` when that is 1 to 3, and a `cfg_cl` of 0 is treated as 1.
- R2: Each further word of a burst appears on the next rising edge, so there are no gaps between the words of one burst.
- R3: A `cfg_bl` code of 0, 1, 2 or 3 gives a fixed burst of 1, 2, 4 or 8 words. Word i reads column (start & ~(N-1)) | ((start+i) & (N-1)), so the sequence wraps inside the aligned N-column block.
- R4: A `cfg_bl` code of 4 to 7 gives a full-page burst. Word i reads column (start+i) mod 256, so the sequence passes from 255 to 0 and continues until stopped.
- R5: On the edge after the last word, `dq_oe` goes low. Whenever `dq_oe` is low, `dq_out` is all zeros.
- R6: The word read from column c is {~c, c}: the inverted column in bits 15:8 and the column in bits 7:0.
- R7: A read sampled while a burst is running restarts the sequence from the new column with the new burst length. The output shows the old words up to the restart and then the new words, with `dq_oe` high throughout.
- R8: If `burst_stop` is sampled on edge S without a read on that edge, no column after those issued before S is read. `dq_oe` goes low just after edge S+L. A read on the same edge as `burst_stop` takes priority and starts a full burst.
- R9: `burst_stop` sampled while no burst is running has no effect, so `dq_oe` stays low.
- R10: While `rst` is high at a rising edge, the sequencer returns to ST_IDLE and the output is cleared. Any burst in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd | input | 1 | Read command strobe |
| rd_col | input | COL_W (8) | Starting column of the read |
| burst_stop | input | 1 | Burst stop request |
| cfg_cl | input | CL_W (2) | CAS latency in clocks |
| cfg_bl | input | 3 | Burst length code |
| dq_out | output | DATA_W (16) | Read data word |
| dq_oe | output | 1 | Data drive enable (low means high impedance) |

## Verification
The burst walk is tried with every fixed length at starting columns in the middle of an aligned block. These cases separate in-block wrapping from plain increment, and they also separate a length counter that is one word long or short. Full-page bursts start near column 255, which exposes any failure to wrap to zero. They stop after a few words, which shows whether the stop is honoured at the right latency. Varying the CAS latency from 1 to 3 across the cases pins down the tap of the delay line. A restart in mid-burst, a stop on the same edge as a read, a stop while idle, and a reset in the middle of a burst show the priority between the sequencer's transitions.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    // Column sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_t;

    // Burst length code bit that selects open-ended page mode
    localparam int BL_PAGE_BIT = 2;

endpackage

// File: rtl/sdram_rd_colgen.sv
module sdram_rd_colgen
    import sdram_rd_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] rd_col,
    input  logic             burst_stop,
    input  logic [2:0]       cfg_bl,
    output logic             gen_vld,
    output logic [COL_W-1:0] gen_col
);

    seq_state_t       state_q, state_d;
    logic [COL_W-1:0] col_q, col_d;
    logic [COL_W-1:0] left_q, left_d;
    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] col_inc;
    logic [COL_W-1:0] col_wrap;
    logic             page_mode;

    assign page_mode = cfg_bl[BL_PAGE_BIT];
    // words remaining after the first one, also the in-block wrap mask
    assign blk_mask  = COL_W'((1 << cfg_bl[1:0]) - 1);
    assign col_inc   = col_q + 1'b1;
    assign col_wrap  = (col_q & ~blk_mask) | (col_inc & blk_mask);

    // next-state and next-output decisions
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        left_d  = left_q;
        if (rd_cmd) begin
            // LAUNCH / RESTART
            state_d = page_mode ? ST_PAGE : ST_FIXED;
            col_d   = rd_col;
            left_d  = blk_mask;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_FIXED: begin
                    if (burst_stop || (left_q == '0)) begin
                        state_d = ST_IDLE;          // STOP or FINISH
                    end else begin
                        col_d  = col_wrap;          // STEP
                        left_d = left_q - 1'b1;
                    end
                end
                ST_PAGE: begin
                    if (burst_stop) begin
                        state_d = ST_IDLE;          // STOP
                    end else begin
                        col_d = col_inc;            // STEP, wraps 255 -> 0
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            left_q <= '0;
        end else begin
            col_q  <= col_d;
            left_q <= left_d;
        end
    end

    assign gen_vld = (state_q != ST_IDLE);
    assign gen_col = col_q;

endmodule

// File: rtl/sdram_rd_latpipe.sv
module sdram_rd_latpipe #(
    parameter  int COL_W  = 8,
    parameter  int MAX_CL = 3,
    localparam int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [COL_W-1:0] in_col,
    input  logic [CL_W-1:0]  cfg_cl,
    output logic             tap_vld,
    output logic [COL_W-1:0] tap_col
);

    logic [CL_W-1:0] tap_sel;

    // latency L taps the stage L-1 behind the sequencer; the array adds one more
    always_comb begin
        if (cfg_cl == '0) begin
            tap_sel = '0;
        end else if (int'(cfg_cl) > MAX_CL) begin
            tap_sel = CL_W'(MAX_CL - 1);
        end else begin
            tap_sel = cfg_cl - 1'b1;
        end
    end

    generate
        if (MAX_CL > 1) begin : g_pipe
            logic             dly_vld [1:MAX_CL-1];
            logic [COL_W-1:0] dly_col [1:MAX_CL-1];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 1; k < MAX_CL; k++) begin
                        dly_vld[k] <= 1'b0;
                        dly_col[k] <= '0;
                    end
                end else begin
                    dly_vld[1] <= in_vld;
                    dly_col[1] <= in_col;
                    for (int k = 2; k < MAX_CL; k++) begin
                        dly_vld[k] <= dly_vld[k-1];
                        dly_col[k] <= dly_col[k-1];
                    end
                end
            end

            always_comb begin
                tap_vld = in_vld;
                tap_col = in_col;
                for (int k = 1; k < MAX_CL; k++) begin
                    if (int'(tap_sel) == k) begin
                        tap_vld = dly_vld[k];
                        tap_col = dly_col[k];
                    end
                end
            end
        end else begin : g_direct
            logic unused_sel;
            assign unused_sel = ^{tap_sel, clk, rst};
            assign tap_vld    = in_vld;
            assign tap_col    = in_col;
        end
    endgenerate

endmodule

// File: rtl/sdram_rd_array.sv
module sdram_rd_array #(
    parameter  int COL_W  = 8,
    parameter  int DATA_W = 16,
    localparam int DEPTH  = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [COL_W-1:0]  rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    function automatic logic [DATA_W-1:0] fill_word(input int idx);
        logic [COL_W-1:0] c;
        c = COL_W'(idx);
        return DATA_W'({~c, c});
    endfunction

    // contents are set by reset; the read path never changes them
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= fill_word(i);
            end
        end
    end

    // synchronous read port
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? cells[rd_addr] : '0;
        end
    end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
    parameter  int COL_W  = 8,
    parameter  int DATA_W = 16,
    parameter  int MAX_CL = 3,
    localparam int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cmd,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              burst_stop,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic [2:0]        cfg_bl,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic             gen_vld;
    logic [COL_W-1:0] gen_col;
    logic             tap_vld;
    logic [COL_W-1:0] tap_col;

    sdram_rd_colgen #(
        .COL_W (COL_W)
    ) u_colgen (
        .clk        (clk),
        .rst        (rst),
        .rd_cmd     (rd_cmd),
        .rd_col     (rd_col),
        .burst_stop (burst_stop),
        .cfg_bl     (cfg_bl),
        .gen_vld    (gen_vld),
        .gen_col    (gen_col)
    );

    sdram_rd_latpipe #(
        .COL_W  (COL_W),
        .MAX_CL (MAX_CL)
    ) u_latpipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (gen_vld),
        .in_col  (gen_col),
        .cfg_cl  (cfg_cl),
        .tap_vld (tap_vld),
        .tap_col (tap_col)
    );

    sdram_rd_array #(
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (tap_vld),
        .rd_addr  (tap_col),
        .rd_valid (dq_oe),
        .rd_data  (dq_out)
    );

endmodule

// File: rtl/sdram_rd_chk.sv
module sdram_rd_chk #(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_cmd,
    input logic [COL_W-1:0]  rd_col,
    input logic              burst_stop,
    input logic [2:0]        cfg_bl,
    input logic              gen_vld,
    input logic [COL_W-1:0]  gen_col,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out
);

    logic [COL_W-1:0] hi_mask;
    assign hi_mask = ~COL_W'((1 << cfg_bl[1:0]) - 1);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!dq_oe && (dq_out == '0)));

    assert_restart_col_R7: assert property (@(posedge clk) disable iff (rst)
        rd_cmd |=> (gen_vld && (gen_col == $past(rd_col))));

    assert_page_step_R4: assert property (@(posedge clk) disable iff (rst)
        (gen_vld && cfg_bl[2] && !rd_cmd && !burst_stop)
        |=> (gen_vld && (gen_col == COL_W'($past(gen_col) + 1'b1))));

    assert_fixed_block_R3: assert property (@(posedge clk) disable iff (rst)
        (gen_vld && !cfg_bl[2] && !rd_cmd)
        |=> (!gen_vld || ((gen_col & hi_mask) == ($past(gen_col) & hi_mask))));

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (rst)
        (gen_vld && burst_stop && !rd_cmd) |=> !gen_vld);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!gen_vld && !rd_cmd) |=> !gen_vld);

    assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_out == '0));

endmodule

bind sdram_rd_seq sdram_rd_chk #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_cmd     (rd_cmd),
    .rd_col     (rd_col),
    .burst_stop (burst_stop),
    .cfg_bl     (cfg_bl),
    .gen_vld    (gen_vld),
    .gen_col    (gen_col),
    .dq_oe      (dq_oe),
    .dq_out     (dq_out)
);

// File: tb/sdram_rd_seq_test.sv
`timescale 1ns/1ps
module sdram_rd_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_cmd = 1'b0;
    logic [7:0]  rd_col = '0;
    logic        burst_stop = 1'b0;
    logic [1:0]  cfg_cl = 2'd3;
    logic [2:0]  cfg_bl = 3'd0;
    logic [15:0] dq_out;
    logic        dq_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_rd_seq uut (
        .clk        (clk),
        .rst        (rst),
        .rd_cmd     (rd_cmd),
        .rd_col     (rd_col),
        .burst_stop (burst_stop),
        .cfg_cl     (cfg_cl),
        .cfg_bl     (cfg_bl),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    // vector: {start column, latency, burst code, stop index (0 = none)}
    localparam int NVEC = 8;
    localparam logic [21:0] VEC [NVEC] = '{
        {8'h00, 2'd3, 3'd0, 9'd0},
        {8'h05, 2'd3, 3'd1, 9'd0},
        {8'h12, 2'd2, 3'd2, 9'd0},
        {8'h3D, 2'd1, 3'd3, 9'd0},
        {8'hFA, 2'd3, 3'd7, 9'd12},
        {8'h80, 2'd2, 3'd4, 9'd5},
        {8'h00, 2'd3, 3'd3, 9'd3},
        {8'hFF, 2'd0, 3'd6, 9'd2}
    };

    function automatic logic [15:0] pat(input logic [7:0] c);
        return {~c, c};
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] c, input int code, input int i);
        logic [7:0] m;
        if (code >= 4) return c + 8'(i);
        m = 8'((1 << code) - 1);
        return (c & ~m) | ((c + 8'(i)) & m);
    endfunction

    task automatic chk(input string req, input logic a_oe, input logic e_oe,
                       input logic [15:0] a_dq, input logic [15:0] e_dq);
        total++;
        if (a_oe !== e_oe || a_dq !== e_dq) begin
            bad++;
            $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, a_oe, a_dq, e_oe, e_dq);
        end
    endtask

    task automatic run_burst(input logic [7:0] c, input int cl, input int code,
                             input int stop_at, input bit stop_with_rd);
        int lat, len, n;
        string tag;
        lat = (cl == 0) ? 1 : cl;
        len = (code >= 4) ? 0 : (1 << code);
        if (code >= 4) n = stop_at;
        else n = (stop_at != 0 && stop_at < len) ? stop_at : len;
        @(negedge clk);
        rd_cmd = 1'b1; rd_col = c; cfg_cl = 2'(cl); cfg_bl = 3'(code);
        burst_stop = stop_with_rd;
        @(posedge clk);
        @(negedge clk);
        rd_cmd = 1'b0; burst_stop = 1'b0;
        for (int k = 1; k <= lat + n + 1; k++) begin
            burst_stop = (stop_at != 0 && k == stop_at);
            @(posedge clk);
            @(negedge clk);
            if (k < lat) begin
                tag = "R1";
                chk(tag, dq_oe, 1'b0, dq_out, 16'h0);
            end else if (k - lat < n) begin
                if (k == lat) tag = "R1 R6";
                else if (code >= 4) tag = "R2 R4";
                else tag = "R2 R3";
                chk(tag, dq_oe, 1'b1, dq_out, pat(exp_col(c, code, k - lat)));
            end else begin
                tag = (stop_at != 0) ? "R8" : "R5";
                chk(tag, dq_oe, 1'b0, dq_out, 16'h0);
            end
        end
        burst_stop = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rcol [8];
        logic       roe  [8];

        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", dq_oe, 1'b0, dq_out, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", dq_oe, 1'b0, dq_out, 16'h0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            run_burst(VEC[v][21:14], int'(VEC[v][13:12]), int'(VEC[v][11:9]),
                      int'(VEC[v][8:0]), 1'b0);
        end

        // R8: stop on the same edge as a read, read wins
        run_burst(8'h21, 3, 1, 0, 1'b1);

        // R9: stop while idle has no effect
        for (int k = 0; k < 4; k++) begin
            burst_stop = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk("R9", dq_oe, 1'b0, dq_out, 16'h0);
        end
        burst_stop = 1'b0;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9", dq_oe, 1'b0, dq_out, 16'h0);
        end

        // R7: restart mid-burst, latency 2, length 4
        rcol = '{8'h00, 8'h00, 8'h12, 8'h13, 8'h47, 8'h44, 8'h45, 8'h46};
        roe  = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
        @(negedge clk);
        rd_cmd = 1'b1; rd_col = 8'h12; cfg_cl = 2'd2; cfg_bl = 3'd2;
        @(posedge clk);
        @(negedge clk);
        rd_cmd = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            rd_cmd = (k == 2);
            if (k == 2) rd_col = 8'h47;
            @(posedge clk);
            @(negedge clk);
            rd_cmd = 1'b0;
            if (k < 8) chk("R7", dq_oe, roe[k], dq_out, roe[k] ? pat(rcol[k]) : 16'h0);
            else chk("R7", dq_oe, 1'b0, dq_out, 16'h0);
        end

        // R10: reset in the middle of a page burst
        @(negedge clk);
        rd_cmd = 1'b1; rd_col = 8'h30; cfg_cl = 2'd1; cfg_bl = 3'd7;
        @(posedge clk);
        @(negedge clk);
        rd_cmd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", dq_oe, 1'b1, dq_out, pat(8'h32));
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10", dq_oe, 1'b0, dq_out, 16'h0);
        rst = 1'b0;
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
            chk("R10", dq_oe, 1'b0, dq_out, 16'h0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule